// File: doc/BRIEF.md
# FPU Microprogram Address Sequencer

This block steps a floating-point unit through microcode. It holds an 8-bit micro-address that indexes a 256-word by 64-bit control store. The store is a constant table computed at elaboration. Each cycle the word at the current address is read, and its upper 48 bits are captured into a register that drives the control bus. The low 16 bits steer sequencing: a 5-bit condition selector, an 8-bit jump target, a hold bit for the control bus and a 2-bit next-address source.

While idle the sequencer parks at address 0. A start strobe carrying a supported opcode and a precision flag sends it to that operation's entry routine. It then advances sequentially, branches on a selected status condition, re-dispatches on the current opcode, or returns to idle. Returning to idle ends the instruction with a one-cycle done pulse. Any exception flag raised while busy overrides the microcode and jumps to a per-exception handler.

Top module: `fpu_useq`

## Requirements
- R1: While reset is high, and on the first cycle after it, uaddr_o is 0x00, busy_o is 0, done_o is 0 and ctrl_o is 0.
- R2: While not busy the address stays at 0x00. exc_i and cond_i have no effect, and a start carrying an unsupported opcode is ignored.
- R3: A start while idle with op_i in 0..4 (0 add, 1 sub, 2 mul, 3 div, 4 multiply-add) moves uaddr_o on the next edge to 16*(2*op_i+dbl_i+1) and sets busy_o. A start with op_i of 5..7, or any start while busy, is ignored.
- R4: Word field [1:0]=0 selects the current address plus one.
- R5: Field [1:0]=1 is a conditional jump. Field [15:11] selects the condition: 0 means always true, and n means cond_i[n-1]. When the condition is true the next address is field [10:3]; otherwise it is the current address plus one.
- R6: Field [1:0]=2 re-dispatches to the entry of the present op_i/dbl_i. With an unsupported opcode the instruction ends as in R7.
- R7: Field [1:0]=3 returns to address 0x00 and clears busy_o. done_o is high for exactly the one cycle after that edge.
- R8: When busy and any exc_i bit is set, the next address is the exception entry, whatever the word says, and no done pulse is produced. exc_i[3] invalid goes to 0xC0, [2] overflow to 0xD0, [1] underflow to 0xE0 and [0] inexact to 0xF0, with priority in that order.
- R9: When word bit 2 is set, ctrl_o keeps its value across that edge.
- R10: Otherwise ctrl_o takes bits [63:16] of the word at the current address on each edge, one cycle behind uaddr_o.
- R11: The store holds the following. For each word the control field is {a,~a,a,~a,a,~a}, where a is the 8-bit address. In routine r = 1..10 (address 16r+k), offsets 0,1,2,4,5,6 step sequentially. Offset 3 jumps conditionally to 16r+8 with selector r. Offset 8 steps sequentially with the hold bit set, and offset 9 re-dispatches. At address 0xC0, 0xD0, 0xE0 and 0xF0 the word steps sequentially. Every other word returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new operation |
| op_i | input | 3 | Operation code |
| dbl_i | input | 1 | Precision flag, 1 for double |
| exc_i | input | 4 | Exception flags: invalid, overflow, underflow, inexact (bit 3 down to 0) |
| cond_i | input | NCOND | Status conditions for branches |
| uaddr_o | output | 8 | Current micro-address |
| busy_o | output | 1 | An instruction is executing |
| done_o | output | 1 | One-cycle end-of-instruction pulse |
| ctrl_o | output | 48 | Registered control bus |

## Verification
Two events can fall in the same cycle: an exception flag, and a microinstruction that returns to idle. An instruction's end is one such case. The bench waits until the sequencer sits on the idle-returning word at 0x17 and raises underflow in that same cycle. It then expects the address to go to 0xE0, busy to stay high and no done pulse. Several simultaneous exception bits, and a start while busy, are handled by the same cycle-by-cycle reference model.

// File: rtl/fpu_useq_pkg.sv
package fpu_useq_pkg;

    localparam int AW      = 8;
    localparam int WW      = 64;
    localparam int SEQ_W   = 16;
    localparam int CTRL_W  = WW - SEQ_W;
    localparam int CSEL_W  = 5;
    localparam int NSEL    = 1 << CSEL_W;
    localparam int NOPS    = 5;
    localparam logic [AW-1:0] IDLE_ADDR = '0;

    typedef enum logic [1:0] {
        SRC_SEQ  = 2'd0,
        SRC_FBK  = 2'd1,
        SRC_DISP = 2'd2,
        SRC_IDLE = 2'd3
    } src_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CSEL_W-1:0] csel;
        logic [AW-1:0]     tgt;
        logic              hold;
        src_e              src;
    } uword_t;

    function automatic logic op_ok(input logic [2:0] op);
        return int'(op) < NOPS;
    endfunction

    function automatic logic [AW-1:0] entry_of(input logic [2:0] op, input logic dbl);
        logic [3:0] slot;
        slot = 4'({op, dbl}) + 4'd1;
        return {slot, 4'h0};
    endfunction

    function automatic logic [AW-1:0] exc_entry(input logic [3:0] exc);
        if (exc[3])      return 8'hC0;
        else if (exc[2]) return 8'hD0;
        else if (exc[1]) return 8'hE0;
        else             return 8'hF0;
    endfunction

    function automatic uword_t store_word(input logic [AW-1:0] a);
        uword_t     w;
        logic [3:0] reg_n;
        logic [3:0] off;
        reg_n  = a[7:4];
        off    = a[3:0];
        w.ctrl = {a, ~a, a, ~a, a, ~a};
        w.csel = '0;
        w.tgt  = '0;
        w.hold = 1'b0;
        w.src  = SRC_IDLE;
        if (reg_n >= 4'd1 && reg_n <= 4'd10) begin
            case (off)
                4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6: w.src = SRC_SEQ;
                4'd3: begin
                    w.src  = SRC_FBK;
                    w.csel = {1'b0, reg_n};
                    w.tgt  = {reg_n, 4'h8};
                end
                4'd8: begin
                    w.src  = SRC_SEQ;
                    w.hold = 1'b1;
                end
                4'd9:    w.src = SRC_DISP;
                default: w.src = SRC_IDLE;
            endcase
        end else if (reg_n >= 4'd12 && off == 4'd0) begin
            w.src = SRC_SEQ;
        end
        return w;
    endfunction

endpackage

// File: rtl/fpu_useq_store.sv
module fpu_useq_store
    import fpu_useq_pkg::*;
(
    input  logic [AW-1:0] addr,
    output uword_t        word
);

    always_comb begin
        word = store_word(addr);
    end

endmodule

// File: rtl/fpu_useq_next.sv
module fpu_useq_next
    import fpu_useq_pkg::*;
#(
    parameter int NCOND = 31
) (
    input  logic [AW-1:0]    cur,
    input  logic             busy,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic             dbl,
    input  logic [3:0]       exc,
    input  logic [NCOND-1:0] cond,
    input  uword_t           word,
    output logic [AW-1:0]    nxt,
    output logic             nxt_busy,
    output logic             ending
);

    localparam int PAD = NSEL - NCOND - 1;

    logic [NSEL-1:0] cond_ext;
    logic            hit;
    logic [AW-1:0]   inc;

    generate
        if (PAD > 0) begin : g_pad
            assign cond_ext = {{PAD{1'b0}}, cond, 1'b1};
        end else begin : g_full
            assign cond_ext = {cond, 1'b1};
        end
    endgenerate

    assign hit = cond_ext[word.csel];
    assign inc = cur + AW'(1);

    always_comb begin
        nxt      = IDLE_ADDR;
        nxt_busy = 1'b0;
        ending   = 1'b0;
        if (!busy) begin
            if (start && op_ok(op)) begin
                nxt      = entry_of(op, dbl);
                nxt_busy = 1'b1;
            end
        end else if (|exc) begin
            nxt      = exc_entry(exc);
            nxt_busy = 1'b1;
        end else begin
            unique case (word.src)
                SRC_SEQ: begin
                    nxt      = inc;
                    nxt_busy = 1'b1;
                end
                SRC_FBK: begin
                    nxt      = hit ? word.tgt : inc;
                    nxt_busy = 1'b1;
                end
                SRC_DISP: begin
                    if (op_ok(op)) begin
                        nxt      = entry_of(op, dbl);
                        nxt_busy = 1'b1;
                    end else begin
                        ending = 1'b1;
                    end
                end
                SRC_IDLE: ending = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/fpu_useq.sv
module fpu_useq
    import fpu_useq_pkg::*;
#(
    parameter int NCOND = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic              dbl_i,
    input  logic [3:0]        exc_i,
    input  logic [NCOND-1:0]  cond_i,
    output logic [AW-1:0]     uaddr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    logic [AW-1:0]     uaddr_q;
    logic              busy_q;
    logic              done_q;
    logic [CTRL_W-1:0] ctrl_q;
    uword_t            word;
    logic [AW-1:0]     nxt;
    logic              nxt_busy;
    logic              ending;

    fpu_useq_store u_store (
        .addr (uaddr_q),
        .word (word)
    );

    fpu_useq_next #(.NCOND(NCOND)) u_next (
        .cur      (uaddr_q),
        .busy     (busy_q),
        .start    (start_i),
        .op       (op_i),
        .dbl      (dbl_i),
        .exc      (exc_i),
        .cond     (cond_i),
        .word     (word),
        .nxt      (nxt),
        .nxt_busy (nxt_busy),
        .ending   (ending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            uaddr_q <= IDLE_ADDR;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            uaddr_q <= nxt;
            busy_q  <= nxt_busy;
            done_q  <= ending;
            if (!word.hold) begin
                ctrl_q <= word.ctrl;
            end
        end
    end

    assign uaddr_o = uaddr_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;
    assign ctrl_o  = ctrl_q;

endmodule

// File: rtl/fpu_useq_chk.sv
module fpu_useq_chk
    import fpu_useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [2:0]        op_i,
    input logic              dbl_i,
    input logic [3:0]        exc_i,
    input logic [AW-1:0]     uaddr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic [WW-1:0]     word_bits
);

    a_r2_idle_addr: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> uaddr_o == IDLE_ADDR);

    a_r3_add_entry: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && op_i == 3'd0 && !dbl_i) |=> (busy_o && uaddr_o == 8'h10));

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (busy_o && exc_i == 4'd0 && word_bits[1:0] == 2'd0) |=> uaddr_o == $past(uaddr_o) + 8'd1);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_done_parked: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && uaddr_o == IDLE_ADDR));

    a_r8_invalid_first: assert property (@(posedge clk) disable iff (rst)
        (busy_o && exc_i[3]) |=> (uaddr_o == 8'hC0 && !done_o));

    a_r9_hold_bus: assert property (@(posedge clk) disable iff (rst)
        word_bits[2] |=> $stable(ctrl_o));

endmodule

bind fpu_useq fpu_useq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .op_i      (op_i),
    .dbl_i     (dbl_i),
    .exc_i     (exc_i),
    .uaddr_o   (uaddr_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ctrl_o    (ctrl_o),
    .word_bits (word)
);

// File: tb/fpu_useq_bench.sv
module fpu_useq_bench;

    localparam int NC = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic          dbl_i = 1'b0;
    logic [3:0]    exc_i = '0;
    logic [NC-1:0] cond_i = '0;
    logic [7:0]    uaddr_o;
    logic          busy_o;
    logic          done_o;
    logic [47:0]   ctrl_o;

    int nchecks = 0;
    int nerr    = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    fpu_useq #(.NCOND(NC)) u_fpu_useq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .op_i    (op_i),
        .dbl_i   (dbl_i),
        .exc_i   (exc_i),
        .cond_i  (cond_i),
        .uaddr_o (uaddr_o),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .ctrl_o  (ctrl_o)
    );

    // Behavioural picture of the store (R11): kind 0 step, 1 branch, 2 dispatch, 3 park
    function automatic int m_kind(input int a);
        int blk = a / 16;
        int pos = a % 16;
        if (blk >= 1 && blk <= 10) begin
            if (pos == 3) return 1;
            if (pos == 9) return 2;
            if (pos <= 8 && pos != 7) return 0;
            return 3;
        end
        if (blk >= 12 && pos == 0) return 0;
        return 3;
    endfunction

    function automatic bit m_hold(input int a);
        return (a / 16 >= 1) && (a / 16 <= 10) && (a % 16 == 8);
    endfunction

    function automatic logic [47:0] m_bus(input int a);
        logic [7:0] b = 8'(a);
        return {b, ~b, b, ~b, b, ~b};
    endfunction

    int          m_addr = 0;
    bit          m_busy = 0;
    bit          m_done = 0;
    logic [47:0] m_ctrl = '0;
    string       m_tag  = "R1";
    string       m_ctag = "R1";
    logic [47:0] m_nc;
    int          m_blk;

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_busy = 0; m_done = 0; m_ctrl = '0;
            m_tag = "R1"; m_ctag = "R1";
        end else begin
            if (m_hold(m_addr)) begin m_nc = m_ctrl; m_ctag = "R9"; end
            else begin m_nc = m_bus(m_addr); m_ctag = "R10"; end
            m_done = 0;
            if (!m_busy) begin
                if (start_i && op_i < 5) begin
                    m_addr = (2 * op_i + dbl_i + 1) * 16; m_busy = 1; m_tag = "R3";
                end else begin
                    m_addr = 0; m_tag = "R2";
                end
            end else if (exc_i != 0) begin
                m_tag = "R8";
                if (exc_i[3]) m_addr = 192;
                else if (exc_i[2]) m_addr = 208;
                else if (exc_i[1]) m_addr = 224;
                else m_addr = 240;
            end else begin
                m_blk = m_addr / 16;
                case (m_kind(m_addr))
                    0: begin m_addr = m_addr + 1; m_tag = "R4"; end
                    1: begin
                        m_tag = "R5";
                        if (cond_i[m_blk - 1]) m_addr = m_blk * 16 + 8;
                        else m_addr = m_addr + 1;
                    end
                    2: begin
                        m_tag = "R6";
                        if (op_i < 5) m_addr = (2 * op_i + dbl_i + 1) * 16;
                        else begin m_addr = 0; m_busy = 0; m_done = 1; end
                    end
                    default: begin m_addr = 0; m_busy = 0; m_done = 1; m_tag = "R7"; end
                endcase
            end
            m_ctrl = m_nc;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        chk({m_tag, " addr"}, 64'(uaddr_o), 64'(m_addr));
        chk({m_tag, " busy"}, 64'(busy_o), 64'(m_busy));
        chk({m_tag, " done"}, 64'(done_o), 64'(m_done));
        chk({m_ctag, " bus"}, 64'(ctrl_o), 64'(m_ctrl));
        if (cyc > 4000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d expected below 4000 cycles", cyc);
            finish_run();
        end
    end

    task automatic kick(input logic [2:0] op, input logic dbl);
        op_i = op; dbl_i = dbl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_addr(input logic [7:0] a);
        int n = 0;
        while (uaddr_o !== a && n < 100) begin @(negedge clk); n++; end
        chk("R4 reach", 64'(uaddr_o), 64'(a));
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 100) begin @(negedge clk); n++; end
    endtask

    initial begin
        @(negedge clk);
        chk("R1 addr", 64'(uaddr_o), 64'h0);
        chk("R1 bus", 64'(ctrl_o), 64'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: idle ignores exceptions and conditions
        exc_i = 4'hF; cond_i = '1;
        repeat (3) @(negedge clk);
        chk("R2 parked", 64'(uaddr_o), 64'h0);
        exc_i = '0; cond_i = '0;

        // single add, branch not taken
        kick(3'd0, 1'b0);
        chk("R3 entry", 64'(uaddr_o), 64'h10);
        @(negedge clk);
        chk("R11 bus word", 64'(ctrl_o), 64'(m_bus(16)));
        wait_idle();
        chk("R7 done", 64'(done_o), 64'h1);

        // double mul, branch taken, start while busy, re-dispatch
        cond_i = 31'h20;
        kick(3'd2, 1'b1);
        start_i = 1'b1; op_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0; op_i = 3'd2;
        wait_addr(8'h63);
        @(negedge clk);
        chk("R5 taken", 64'(uaddr_o), 64'h68);
        wait_addr(8'h69);
        op_i = 3'd1; dbl_i = 1'b0; cond_i = '0;
        @(negedge clk);
        chk("R6 dispatch", 64'(uaddr_o), 64'h30);
        wait_idle();

        // multiply-add with two exceptions at once
        kick(3'd4, 1'b1);
        wait_addr(8'hA2);
        exc_i = 4'b0101;
        @(negedge clk);
        exc_i = '0;
        chk("R8 overflow", 64'(uaddr_o), 64'hD0);
        wait_idle();

        // exception in the same cycle as the park word
        kick(3'd0, 1'b0);
        wait_addr(8'h17);
        exc_i = 4'b0010;
        @(negedge clk);
        exc_i = '0;
        chk("R8 underflow", 64'(uaddr_o), 64'hE0);
        chk("R8 no done", 64'(done_o), 64'h0);
        wait_idle();

        // unsupported opcode start
        kick(3'd6, 1'b0);
        chk("R3 bad op", 64'(busy_o), 64'h0);

        // dispatch on unsupported opcode ends the instruction
        cond_i = 31'h40;
        kick(3'd3, 1'b0);
        wait_addr(8'h79);
        op_i = 3'd7;
        @(negedge clk);
        chk("R6 end busy", 64'(busy_o), 64'h0);
        chk("R6 end done", 64'(done_o), 64'h1);
        cond_i = '0;

        // all exceptions at once
        kick(3'd1, 1'b1);
        wait_addr(8'h41);
        exc_i = 4'hF;
        @(negedge clk);
        exc_i = '0;
        chk("R8 invalid", 64'(uaddr_o), 64'hC0);
        wait_idle();

        // reset in the middle of a routine
        kick(3'd0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid addr", 64'(uaddr_o), 64'h0);
        chk("R1 mid busy", 64'(busy_o), 64'h0);
        chk("R1 mid bus", 64'(ctrl_o), 64'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule